// File: doc/BRIEF.md
# Single-Digit BCD Up/Down Counter with Separate Count Clocks

This block holds one decimal digit in 8421 BCD and moves it by one step on a rising edge of either of two count inputs. One input counts up and the other counts down. It also has an active-high master clear, an active-low preset from a 4-bit value, and two active-low terminal-count outputs. The carry output follows the low phase of the up input while the digit sits at its top value. The borrow output follows the low phase of the down input while the digit sits at zero. Each terminal-count output can drive the matching count input of the next higher digit directly, so digits chain without glue logic.

The design is synchronous to one system clock `clk`. Both count inputs pass through a two-flop synchronizer, and a count event is a 0-to-1 change of the synchronized value. The digit register updates on the third rising edge of `clk` after a count input changes. The master clear and the preset act on the digit register at the next `clk` edge. They win over any count event in the same cycle. `rst_n` sets the digit to zero and the synchronizers to their idle-high value.

Top module: `bcd_updown_counter`

## Requirements
- R1: While `mreset` is high, `q` becomes 0 at the next `clk` edge, whatever `load_n`, `preset`, `up_clk` and `dn_clk` are doing.
- R2: While `mreset` is low and `load_n` is low, `q` takes `preset` at the next `clk` edge and ignores every count event.
- R3: A rising edge on `up_clk` while `dn_clk` stays high adds one to `q`, and 9 wraps to 0. `q` changes on the third `clk` edge after the input change. In a cascade, the lower digit's `carry_n` drives the upper digit's `up_clk`, and the two digits count as a decimal pair.
- R4: A rising edge on `dn_clk` while `up_clk` stays high subtracts one from `q`, and 0 wraps to 9. In a cascade, `borrow_n` drives the upper digit's `dn_clk`.
- R5: `q` holds when neither input rises. It also holds when both inputs rise in the same synchronized cycle.
- R6: A rising edge on one count input while the other input is low is ignored.
- R7: `carry_n` is low exactly when `q[0]` and `q[3]` are both 1 and the synchronized `up_clk` is low. For BCD codes this means the value 9.
- R8: `borrow_n` is low exactly when `q` is 0 and the synchronized `dn_clk` is low.
- R9: If a count input is held low through a master clear or a preset, its first rising edge after the override ends is counted.
- R10: A preset code from 10 to 15 counts up modulo 16 (15 goes to 0) and counts down by plain decrement.
- R11: After `rst_n` is released, `q` is 0 and both terminal-count outputs are high while both count inputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| mreset | input | 1 | Active-high master clear of the digit |
| load_n | input | 1 | Active-low preset strobe |
| preset | input | 4 | Value loaded while `load_n` is low |
| up_clk | input | 1 | Count-up input, rising edge counts |
| dn_clk | input | 1 | Count-down input, rising edge counts |
| q | output | 4 | Digit value, 8421 BCD, bit 0 least significant |
| carry_n | output | 1 | Active-low terminal count for counting up |
| borrow_n | output | 1 | Active-low terminal count for counting down |

## Verification
The case that is hardest to produce from the ports is two count inputs whose synchronized rising edges land in the same system cycle. The bench gets there by first lowering both inputs and letting them settle. It then raises both on the same falling edge of `clk`, so both synchronizers see the change together. The second hard case is an input held low across a master clear. The bench lowers `up_clk` before asserting `mreset`, releases the clear, checks that `q` is still 0, and only then raises the input. A two-digit chain, driven only through the lower digit's count inputs, checks the carry and borrow timing.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;
  localparam int DIGIT_W   = 4;
  localparam int DIGIT_TOP = 9;

  typedef logic [DIGIT_W-1:0] digit_t;

  // next value when counting up: top wraps to zero, codes above top run modulo 16
  function automatic digit_t step_up(input digit_t cur);
    if (cur == digit_t'(DIGIT_TOP)) return '0;
    return cur + digit_t'(1);
  endfunction

  // next value when counting down: zero wraps to top, other codes plain decrement
  function automatic digit_t step_down(input digit_t cur);
    if (cur == '0) return digit_t'(DIGIT_TOP);
    return cur - digit_t'(1);
  endfunction

  // carry condition decodes only bits 0 and 3
  function automatic logic top_decode(input digit_t cur);
    return cur[0] & cur[DIGIT_W-1];
  endfunction

  function automatic logic zero_decode(input digit_t cur);
    return (cur == '0);
  endfunction
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int   STAGES   = 2,
  parameter logic IDLE_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic rise
);
  localparam int CHAIN_W = STAGES + 1;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {CHAIN_W{IDLE_VAL}};
    else        chain <= {chain[CHAIN_W-2:0], din};
  end

  assign lvl  = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/bcd_count_core.sv
module bcd_count_core
  import bcd_cnt_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   mreset,
  input  logic   load_n,
  input  digit_t preset,
  input  logic   inc,
  input  logic   dec,
  output digit_t q
);
  digit_t q_next;

  always_comb begin
    q_next = q;
    if (mreset)       q_next = '0;
    else if (!load_n) q_next = preset;
    else if (inc)     q_next = step_up(q);
    else if (dec)     q_next = step_down(q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end
endmodule

// File: rtl/tc_gen.sv
module tc_gen
  import bcd_cnt_pkg::*;
(
  input  digit_t q,
  input  logic   up_lvl,
  input  logic   dn_lvl,
  output logic   carry_n,
  output logic   borrow_n
);
  assign carry_n  = ~(top_decode(q)  & ~up_lvl);
  assign borrow_n = ~(zero_decode(q) & ~dn_lvl);
endmodule

// File: rtl/bcd_updown_counter.sv
module bcd_updown_counter
  import bcd_cnt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mreset,
  input  logic                load_n,
  input  logic [DIGIT_W-1:0]  preset,
  input  logic                up_clk,
  input  logic                dn_clk,
  output logic [DIGIT_W-1:0]  q,
  output logic                carry_n,
  output logic                borrow_n
);
  localparam int N_CLK = 2;
  localparam int UP_IX = 0;
  localparam int DN_IX = 1;

  logic [N_CLK-1:0] raw_clk;
  logic [N_CLK-1:0] lvl_vec;
  logic [N_CLK-1:0] rise_vec;

  assign raw_clk = {dn_clk, up_clk};

  for (genvar i = 0; i < N_CLK; i++) begin : g_sync
    edge_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_sync (
      .clk (clk),
      .rst_n (rst_n),
      .din (raw_clk[i]),
      .lvl (lvl_vec[i]),
      .rise (rise_vec[i])
    );
  end

  // named internal events, observed by the bound checker
  logic up_lvl, dn_lvl, up_rise, dn_rise, inc_evt, dec_evt;
  assign up_lvl  = lvl_vec[UP_IX];
  assign dn_lvl  = lvl_vec[DN_IX];
  assign up_rise = rise_vec[UP_IX];
  assign dn_rise = rise_vec[DN_IX];
  // a count is valid only with the other input resting high and not rising too
  assign inc_evt = up_rise & ~dn_rise & dn_lvl;
  assign dec_evt = dn_rise & ~up_rise & up_lvl;

  bcd_count_core u_core (
    .clk (clk),
    .rst_n (rst_n),
    .mreset (mreset),
    .load_n (load_n),
    .preset (preset),
    .inc (inc_evt),
    .dec (dec_evt),
    .q (q)
  );

  tc_gen u_tc (
    .q (q),
    .up_lvl (up_lvl),
    .dn_lvl (dn_lvl),
    .carry_n (carry_n),
    .borrow_n (borrow_n)
  );
endmodule

// File: rtl/bcd_updown_counter_chk.sv
module bcd_updown_counter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mreset,
  input logic       load_n,
  input logic [3:0] preset,
  input logic [3:0] q,
  input logic       carry_n,
  input logic       borrow_n,
  input logic       up_lvl,
  input logic       dn_lvl,
  input logic       up_rise,
  input logic       dn_rise,
  input logic       inc_evt,
  input logic       dec_evt
);
  p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mreset |=> (q == 4'd0));

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mreset && !load_n) |=> (q == $past(preset)));

  p_up_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_evt && !mreset && load_n && q < 4'd9) |=> (q == $past(q) + 4'd1));

  p_down_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_evt && !mreset && load_n && q != 4'd0) |=> (q == $past(q) - 4'd1));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mreset && load_n && ((!up_rise && !dn_rise) || (up_rise && dn_rise))) |=> $stable(q));

  p_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mreset && load_n && up_rise && !dn_lvl && !dn_rise) |=> $stable(q));

  p_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_n |-> (q[0] && q[3] && !up_lvl));

  p_borrow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !borrow_n |-> (q == 4'd0 && !dn_lvl));

  p_one_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc_evt && dec_evt));
endmodule

bind bcd_updown_counter bcd_updown_counter_chk u_chk (
  .clk (clk),
  .rst_n (rst_n),
  .mreset (mreset),
  .load_n (load_n),
  .preset (preset),
  .q (q),
  .carry_n (carry_n),
  .borrow_n (borrow_n),
  .up_lvl (up_lvl),
  .dn_lvl (dn_lvl),
  .up_rise (up_rise),
  .dn_rise (dn_rise),
  .inc_evt (inc_evt),
  .dec_evt (dec_evt)
);

// File: tb/bcd_updown_counter_bench.sv
`timescale 1ns/1ps
module bcd_updown_counter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mreset = 1'b0;
  logic       load_n = 1'b1;
  logic [3:0] preset = 4'd0;
  logic       up_clk = 1'b1;
  logic       dn_clk = 1'b1;
  logic [3:0] q;
  logic       carry_n, borrow_n;
  logic       mreset_hi = 1'b0;
  logic [3:0] q_hi;
  logic       carry_hi_n, borrow_hi_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  bcd_updown_counter u_bcd_updown_counter (
    .clk (clk), .rst_n (rst_n), .mreset (mreset), .load_n (load_n),
    .preset (preset), .up_clk (up_clk), .dn_clk (dn_clk),
    .q (q), .carry_n (carry_n), .borrow_n (borrow_n)
  );

  // upper digit of the cascade, clocked only by the lower digit's terminal counts
  bcd_updown_counter u_hi (
    .clk (clk), .rst_n (rst_n), .mreset (mreset_hi), .load_n (1'b1),
    .preset (4'd0), .up_clk (carry_n), .dn_clk (borrow_n),
    .q (q_hi), .carry_n (carry_hi_n), .borrow_n (borrow_hi_n)
  );

  typedef struct {
    string      tag;
    logic [3:0] q;
    logic       c;
    logic       b;
    bit         use_hi;
    logic [3:0] hi;
  } exp_t;

  exp_t sb_q[$];
  event sample_ev;

  // monitor: pops expected items and compares with the ports
  initial begin
    forever begin
      @(sample_ev);
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (q !== e.q || carry_n !== e.c || borrow_n !== e.b ||
            (e.use_hi && q_hi !== e.hi)) begin
          fails++;
          $display("FAIL %s: q=%0d carry_n=%b borrow_n=%b hi=%0d expected q=%0d carry_n=%b borrow_n=%b hi=%0d",
                   e.tag, q, carry_n, borrow_n, q_hi, e.q, e.c, e.b, e.hi);
        end
      end
    end
  end

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic expect_now(input string tag, input logic [3:0] eq,
                            input logic ec, input logic eb);
    exp_t e;
    e.tag = tag; e.q = eq; e.c = ec; e.b = eb; e.use_hi = 1'b0; e.hi = 4'd0;
    sb_q.push_back(e);
    ->sample_ev;
    @(negedge clk);
  endtask

  task automatic expect_pair(input string tag, input logic [3:0] ehi,
                             input logic [3:0] elo);
    exp_t e;
    e.tag = tag; e.q = elo; e.c = 1'b1; e.b = 1'b1; e.use_hi = 1'b1; e.hi = ehi;
    sb_q.push_back(e);
    ->sample_ev;
    @(negedge clk);
  endtask

  task automatic pulse_up();
    up_clk = 1'b0; settle();
    up_clk = 1'b1; settle();
  endtask

  task automatic pulse_dn();
    dn_clk = 1'b0; settle();
    dn_clk = 1'b1; settle();
  endtask

  task automatic do_load(input logic [3:0] v);
    preset = v; load_n = 1'b0; @(negedge clk);
    load_n = 1'b1; settle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    expect_now("R11 reset state", 4'd0, 1'b1, 1'b1);

    do_load(4'd7);
    expect_now("R2 preset 7", 4'd7, 1'b1, 1'b1);
    pulse_up();
    expect_now("R3 up 7->8", 4'd8, 1'b1, 1'b1);
    pulse_up();
    expect_now("R3 up 8->9", 4'd9, 1'b1, 1'b1);
    up_clk = 1'b0; settle();
    expect_now("R7 carry low at 9", 4'd9, 1'b0, 1'b1);
    up_clk = 1'b1; settle();
    expect_now("R3 wrap 9->0", 4'd0, 1'b1, 1'b1);

    dn_clk = 1'b0; settle();
    expect_now("R8 borrow low at 0", 4'd0, 1'b1, 1'b0);
    dn_clk = 1'b1; settle();
    expect_now("R4 wrap 0->9", 4'd9, 1'b1, 1'b1);
    pulse_dn();
    expect_now("R4 down 9->8", 4'd8, 1'b1, 1'b1);

    dn_clk = 1'b0; settle();
    pulse_up();
    expect_now("R6 up edge with down low ignored", 4'd8, 1'b1, 1'b1);
    dn_clk = 1'b1; settle();
    expect_now("R4 down 8->7 after release", 4'd7, 1'b1, 1'b1);

    repeat (6) @(negedge clk);
    expect_now("R5 idle hold", 4'd7, 1'b1, 1'b1);
    up_clk = 1'b0; dn_clk = 1'b0; settle();
    up_clk = 1'b1; dn_clk = 1'b1; settle();
    expect_now("R5 simultaneous edges hold", 4'd7, 1'b1, 1'b1);

    preset = 4'd3; load_n = 1'b0; mreset = 1'b1;
    up_clk = 1'b0; settle();
    up_clk = 1'b1; settle();
    expect_now("R1 clear over load and up edge", 4'd0, 1'b1, 1'b1);
    mreset = 1'b0; load_n = 1'b1; settle();

    up_clk = 1'b0; @(negedge clk);
    mreset = 1'b1; settle();
    mreset = 1'b0; settle();
    expect_now("R9 still clear while up held low", 4'd0, 1'b1, 1'b1);
    up_clk = 1'b1; settle();
    expect_now("R9 first edge after clear counted", 4'd1, 1'b1, 1'b1);

    preset = 4'd5; load_n = 1'b0;
    pulse_up();
    expect_now("R2 load held over up edge", 4'd5, 1'b1, 1'b1);
    load_n = 1'b1; settle();

    do_load(4'd14);
    pulse_up();
    expect_now("R10 up 14->15", 4'd15, 1'b1, 1'b1);
    pulse_up();
    expect_now("R10 up 15->0", 4'd0, 1'b1, 1'b1);
    do_load(4'd12);
    pulse_dn();
    expect_now("R10 down 12->11", 4'd11, 1'b1, 1'b1);
    up_clk = 1'b0; settle();
    expect_now("R7 carry low at code 11", 4'd11, 1'b0, 1'b1);
    up_clk = 1'b1; settle();

    mreset = 1'b1; mreset_hi = 1'b1; settle();
    mreset = 1'b0; mreset_hi = 1'b0; settle();
    for (int k = 0; k < 23; k++) pulse_up();
    repeat (4) @(negedge clk);
    expect_pair("R3 cascade up to 23", 4'd2, 4'd3);
    for (int k = 0; k < 5; k++) pulse_dn();
    repeat (4) @(negedge clk);
    expect_pair("R4 cascade down to 18", 4'd1, 4'd8);

    done = 1'b1;
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule